// File: doc/BRIEF.md
# Overlay Sync Generator and Sampler

This block drives the horizontal and vertical sync pulses that an external on-screen-display source uses to time its output. It also captures the overlay pixels that the source returns. Everything runs in the overlay clock domain. A line-active input marks the stretch of each line during which valid video is being processed internally. A pixel position counter restarts at every line, and a line counter restarts on a frame-start pulse. All timing is derived from these two counters.

The source returns pixels two at a time, with even pixels on one port and odd pixels on the other. Both ports are sampled on the same edge. The capture window opens a programmable number of clocks after the leading edge of the generated hsync. The window's width is the programmed number of pixel pairs. The trailing edge of hsync plays no part in capture. Captured pairs are buffered and serialised into a single pixel stream, even pixel first.

When clock gating is enabled, a clock-enable output drops during internal blanking. All configuration inputs are shadowed during blanking, so a line that is in progress always runs with one consistent setting.

Top module: `ovl_sync_sampler`

## Requirements
- R1: The position counter counts clock edges at which line_act_i is high, starting from 0 at the first such edge of a line. The active hsync level first appears in the cycle after the edge at which the position equals cfg_hs_start_i.
- R2: When cfg_hs_pol_i is 0, hsync is active high. When it is 1, hsync is active low. Outside a pulse, hsync_o rests at the level equal to cfg_hs_pol_i.
- R3: The hsync pulse stays active for cfg_hs_len_i cycles. A length of 0 gives no pulse. A pulse that would outlast the line is cut off at the line's end.
- R4: Lines are numbered from 0 after frame_start_i, and the number increments at each falling edge of line_act_i. vsync_o is high, active high, for exactly the active cycles of the line whose number equals cfg_vs_line_i.
- R5: While line_act_i is low, there is no hsync activity, no vsync and no capture.
- R6: Pixel pairs are captured at the edges whose position p satisfies S+LAT <= p < S+LAT+N. Here S is cfg_hs_start_i, LAT is cfg_latency_i and N is cfg_pairs_i. The window does not depend on cfg_hs_len_i. ovl_act_o is high in the cycle after each capture edge.
- R7: Each captured pair appears on pix_o as two consecutive valid cycles: the pix_even_i value first, then the pix_odd_i value. Pairs appear in capture order. The first pixel is valid in the cycle after the edge at position S+LAT+1, and pix_vld_o stays high for 2N consecutive cycles.
- R8: With N <= 2*(FIFO_DEPTH-1), the pair buffer never overflows.
- R9: clk_en_o is combinationally low only while gate_en_i is 1 and line_act_i is 0. Otherwise it is high.
- R10: Configuration is captured at every edge where line_act_i is low. A change made while a line is active has no effect until the next line.
- R11: During reset, hsync_o, vsync_o, ovl_act_o and pix_vld_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Overlay clock |
| rst_ni | input | 1 | Active-low reset |
| line_act_i | input | 1 | High while valid video is processed internally |
| frame_start_i | input | 1 | Restarts line numbering at 0 |
| gate_en_i | input | 1 | Enables blanking clock gating |
| cfg_hs_start_i | input | POS_W | Hsync start position |
| cfg_hs_len_i | input | POS_W | Hsync length in clocks |
| cfg_hs_pol_i | input | 1 | Hsync polarity, 1 = active low |
| cfg_vs_line_i | input | LINE_W | Line number carrying vsync |
| cfg_latency_i | input | LAT_W | Clocks from hsync start to first capture |
| cfg_pairs_i | input | POS_W | Pixel pairs captured per line |
| pix_even_i | input | PIX_W | Even pixel from the source |
| pix_odd_i | input | PIX_W | Odd pixel from the source |
| hsync_o | output | 1 | Horizontal sync toward the source |
| vsync_o | output | 1 | Vertical sync toward the source |
| ovl_act_o | output | 1 | Capture in progress |
| clk_en_o | output | 1 | Overlay clock enable |
| pix_o | output | PIX_W | Serialised overlay pixel |
| pix_vld_o | output | 1 | pix_o carries a pixel |

## Verification
The bench programs an hsync longer than the line. A design that let the pulse run on into blanking would show hsync activity there. It also programs a latency that opens the capture window only after hsync has ended. A design that gated capture with the pulse itself would capture nothing in that case. A zero-length pulse must give no sync but still a full capture. A start position rewritten partway through a line must leave that line's pulse where it was, which catches missing shadowing. The serialised stream is compared value by value against consecutive even and odd inputs, and vsync is counted per line across a frame. These catch swapped ports, dropped pairs and a line counter that is off by one.

// File: rtl/ovl_sync_pkg.sv
`timescale 1ns/1ps
package ovl_sync_pkg;

   typedef enum logic {
      PH_EVEN = 1'b0,
      PH_ODD  = 1'b1
   } pair_phase_e;

   // true when pos lies in [start, start+len)
   function automatic logic in_span(input int unsigned pos,
                                    input int unsigned start,
                                    input int unsigned len);
      return (pos >= start) && ((pos - start) < len);
   endfunction

endpackage

// File: rtl/ovl_pos_track.sv
`timescale 1ns/1ps
module ovl_pos_track #(
   parameter int POS_W  = 11,
   parameter int LINE_W = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_act_i,
   input  logic              frame_start_i,
   output logic [POS_W-1:0]  pos_o,
   output logic [LINE_W-1:0] line_o
);
   localparam logic [POS_W-1:0]  POS_MAX  = {POS_W{1'b1}};
   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

   logic act_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_o  <= '0;
         line_o <= '0;
         act_d  <= 1'b0;
      end else begin
         act_d <= line_act_i;
         if (!line_act_i)          pos_o <= '0;
         else if (pos_o != POS_MAX) pos_o <= pos_o + 1'b1;
         if (frame_start_i)
            line_o <= '0;
         else if (!line_act_i && act_d && line_o != LINE_MAX)
            line_o <= line_o + 1'b1;
      end
   end
endmodule

// File: rtl/ovl_cfg_shadow.sv
`timescale 1ns/1ps
module ovl_cfg_shadow #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         line_act_i,
   input  logic [W-1:0] cfg_i,
   output logic [W-1:0] cfg_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cfg_o <= '0;
      else if (!line_act_i) cfg_o <= cfg_i;
   end
endmodule

// File: rtl/ovl_sync_gen.sv
`timescale 1ns/1ps
module ovl_sync_gen
   import ovl_sync_pkg::*;
#(
   parameter int POS_W  = 11,
   parameter int LINE_W = 11,
   parameter int LAT_W  = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_act_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [POS_W-1:0]  hs_start_i,
   input  logic [POS_W-1:0]  hs_len_i,
   input  logic              hs_pol_i,
   input  logic [LINE_W-1:0] vs_line_i,
   input  logic [LAT_W-1:0]  latency_i,
   input  logic [POS_W-1:0]  pairs_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              cap_o,
   output logic              ovl_act_o
);
   logic                hs_act;
   logic                vs_q;
   logic                act_q;
   int unsigned         win_start;

   assign win_start = 32'(hs_start_i) + 32'(latency_i);
   assign cap_o     = line_act_i && in_span(32'(pos_i), win_start, 32'(pairs_i));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hs_act <= 1'b0;
         vs_q   <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         hs_act <= line_act_i && in_span(32'(pos_i), 32'(hs_start_i), 32'(hs_len_i));
         vs_q   <= line_act_i && (line_i == vs_line_i);
         act_q  <= cap_o;
      end
   end

   assign hsync_o   = hs_act ^ hs_pol_i;
   assign vsync_o   = vs_q;
   assign ovl_act_o = act_q;

   // R5: no hsync pulse after a blanking edge
   p_hs_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(line_act_i) |-> !hs_act);
endmodule

// File: rtl/ovl_pair_serializer.sv
`timescale 1ns/1ps
module ovl_pair_serializer
   import ovl_sync_pkg::*;
#(
   parameter int PIX_W      = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic [PIX_W-1:0] even_i,
   input  logic [PIX_W-1:0] odd_i,
   output logic [PIX_W-1:0] pix_o,
   output logic             vld_o
);
   localparam int AW = $clog2(FIFO_DEPTH);
   localparam int EW = 2 * PIX_W;
   localparam logic [AW:0] CNT_FULL = (AW + 1)'(FIFO_DEPTH);

   logic [EW-1:0] ent_arr [FIFO_DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   cnt;
   pair_phase_e   phase;
   logic          pop;
   logic          out_odd_q;

   for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_ent
      logic [EW-1:0] ent_q;
      always_ff @(posedge clk_i) begin
         if (push_i && wr_ptr == AW'(i)) ent_q <= {even_i, odd_i};
      end
      assign ent_arr[i] = ent_q;
   end

   assign pop = (phase == PH_ODD);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         cnt       <= '0;
         phase     <= PH_EVEN;
         pix_o     <= '0;
         vld_o     <= 1'b0;
         out_odd_q <= 1'b0;
      end else begin
         if (push_i) wr_ptr <= wr_ptr + 1'b1;
         cnt <= cnt + (AW + 1)'(push_i) - (AW + 1)'(pop);
         if (phase == PH_EVEN) begin
            if (cnt != '0) begin
               pix_o     <= ent_arr[rd_ptr][EW-1:PIX_W];
               vld_o     <= 1'b1;
               out_odd_q <= 1'b0;
               phase     <= PH_ODD;
            end else begin
               vld_o <= 1'b0;
            end
         end else begin
            pix_o     <= ent_arr[rd_ptr][PIX_W-1:0];
            vld_o     <= 1'b1;
            out_odd_q <= 1'b1;
            rd_ptr    <= rd_ptr + 1'b1;
            phase     <= PH_EVEN;
         end
      end
   end

   // R8: pair buffer never written while full
   p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(push_i && !pop && cnt == CNT_FULL));

   // R7: the stream never stops between the two halves of a pair
   p_pair_complete_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(vld_o) |-> $past(out_odd_q));
endmodule

// File: rtl/ovl_sync_sampler.sv
`timescale 1ns/1ps
module ovl_sync_sampler #(
   parameter int PIX_W      = 8,
   parameter int POS_W      = 11,
   parameter int LINE_W     = 11,
   parameter int LAT_W      = 6,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_act_i,
   input  logic              frame_start_i,
   input  logic              gate_en_i,
   input  logic [POS_W-1:0]  cfg_hs_start_i,
   input  logic [POS_W-1:0]  cfg_hs_len_i,
   input  logic              cfg_hs_pol_i,
   input  logic [LINE_W-1:0] cfg_vs_line_i,
   input  logic [LAT_W-1:0]  cfg_latency_i,
   input  logic [POS_W-1:0]  cfg_pairs_i,
   input  logic [PIX_W-1:0]  pix_even_i,
   input  logic [PIX_W-1:0]  pix_odd_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              ovl_act_o,
   output logic              clk_en_o,
   output logic [PIX_W-1:0]  pix_o,
   output logic              pix_vld_o
);
   localparam int CFG_W = 3 * POS_W + 1 + LINE_W + LAT_W;

   initial begin
      a_depth_pow2: assert (FIFO_DEPTH >= 2 && (FIFO_DEPTH & (FIFO_DEPTH - 1)) == 0)
         else $error("FIFO_DEPTH must be a power of two of at least 2");
      a_widths: assert (PIX_W >= 1 && POS_W >= 2 && LINE_W >= 1 && LAT_W >= 1)
         else $error("field widths out of range");
   end

   logic [POS_W-1:0]  pos;
   logic [LINE_W-1:0] line_no;
   logic [CFG_W-1:0]  cfg_raw, cfg_sh;
   logic [POS_W-1:0]  sh_start, sh_len, sh_pairs;
   logic              sh_pol;
   logic [LINE_W-1:0] sh_vs;
   logic [LAT_W-1:0]  sh_lat;
   logic              cap;

   assign cfg_raw = {cfg_hs_start_i, cfg_hs_len_i, cfg_hs_pol_i,
                     cfg_vs_line_i, cfg_latency_i, cfg_pairs_i};
   assign {sh_start, sh_len, sh_pol, sh_vs, sh_lat, sh_pairs} = cfg_sh;

   ovl_pos_track #(.POS_W(POS_W), .LINE_W(LINE_W)) u_pos (
      .clk_i, .rst_ni, .line_act_i, .frame_start_i,
      .pos_o(pos), .line_o(line_no));

   ovl_cfg_shadow #(.W(CFG_W)) u_shadow (
      .clk_i, .rst_ni, .line_act_i, .cfg_i(cfg_raw), .cfg_o(cfg_sh));

   ovl_sync_gen #(.POS_W(POS_W), .LINE_W(LINE_W), .LAT_W(LAT_W)) u_sync (
      .clk_i, .rst_ni, .line_act_i, .pos_i(pos), .line_i(line_no),
      .hs_start_i(sh_start), .hs_len_i(sh_len), .hs_pol_i(sh_pol),
      .vs_line_i(sh_vs), .latency_i(sh_lat), .pairs_i(sh_pairs),
      .hsync_o, .vsync_o, .cap_o(cap), .ovl_act_o);

   ovl_pair_serializer #(.PIX_W(PIX_W), .FIFO_DEPTH(FIFO_DEPTH)) u_ser (
      .clk_i, .rst_ni, .push_i(cap), .even_i(pix_even_i), .odd_i(pix_odd_i),
      .pix_o, .vld_o(pix_vld_o));

   assign clk_en_o = ~gate_en_i | line_act_i;

   // R5: capture and vsync only follow active edges
   p_no_blank_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_act_o |-> $past(line_act_i));
   p_vs_active_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_o |-> $past(line_act_i));
endmodule

// File: tb/ovl_sync_sampler_tb.sv
`timescale 1ns/1ps
module ovl_sync_sampler_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_act = 1'b0, frame_start = 1'b0, gate_en = 1'b0;
   logic [10:0] cfg_hs_start = '0, cfg_hs_len = '0, cfg_pairs = '0;
   logic        cfg_hs_pol = 1'b0;
   logic [10:0] cfg_vs_line = 11'd2047;
   logic [5:0]  cfg_latency = '0;
   logic [7:0]  pix_even = '0, pix_odd = '0;
   logic        hsync, vsync, ovl_act, clk_en, pix_vld;
   logic [7:0]  pix;

   int n_checks = 0, n_fail = 0;
   int hs_first, hs_cnt, blank_hs, blank_act, act_first, act_cnt;
   int pix_first, pix_cnt, pix_err, vs_cnt, idle_lvl;

   typedef struct packed { int s; int l; int pol; int lat; int n; } vec_t;
   localparam vec_t VECS [6] = '{
      '{3, 1, 0, 0, 4},
      '{5, 6, 1, 2, 5},
      '{0, 50, 0, 4, 10},
      '{10, 2, 0, 7, 8},
      '{20, 3, 1, 1, 12},
      '{4, 0, 0, 3, 3}
   };

   always #5 clk = ~clk;

   ovl_sync_sampler u_dut (
      .clk_i(clk), .rst_ni(rst_n), .line_act_i(line_act), .frame_start_i(frame_start),
      .gate_en_i(gate_en), .cfg_hs_start_i(cfg_hs_start), .cfg_hs_len_i(cfg_hs_len),
      .cfg_hs_pol_i(cfg_hs_pol), .cfg_vs_line_i(cfg_vs_line), .cfg_latency_i(cfg_latency),
      .cfg_pairs_i(cfg_pairs), .pix_even_i(pix_even), .pix_odd_i(pix_odd),
      .hsync_o(hsync), .vsync_o(vsync), .ovl_act_o(ovl_act), .clk_en_o(clk_en),
      .pix_o(pix), .pix_vld_o(pix_vld));

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         line_act = 1'b0;
         @(posedge clk); @(negedge clk);
      end
   endtask

   // drives one line plus blanking; observes each cycle after edge k
   task automatic run_line(input int len, input int blank, input int off, input int pol,
                           input int base, input int chg_k, input int chg_val);
      int exp_pix;
      hs_first = -1; hs_cnt = 0; blank_hs = 0; blank_act = 0;
      act_first = -1; act_cnt = 0; pix_first = -1; pix_cnt = 0; pix_err = 0; vs_cnt = 0;
      exp_pix = base;
      for (int k = 0; k < len + blank; k++) begin
         line_act = (k < len);
         pix_even = 8'(2 * k + off);
         pix_odd  = 8'(2 * k + 1 + off);
         if (k == chg_k) cfg_hs_start = 11'(chg_val);
         @(posedge clk); @(negedge clk);
         if ((32'(hsync) ^ pol) != 0) begin
            if (k < len) begin
               if (hs_first < 0) hs_first = k;
               hs_cnt++;
            end else blank_hs++;
         end
         if (ovl_act) begin
            if (k < len) begin
               if (act_first < 0) act_first = k;
               act_cnt++;
            end else blank_act++;
         end
         if (vsync) vs_cnt++;
         if (pix_vld) begin
            if (pix_first < 0) pix_first = k;
            if (pix != 8'(exp_pix)) pix_err++;
            exp_pix++;
            pix_cnt++;
         end
      end
      idle_lvl = 32'(hsync);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 hsync in reset", 32'(hsync), 0);
      check("R11 vsync in reset", 32'(vsync), 0);
      check("R11 ovl_act in reset", 32'(ovl_act), 0);
      check("R11 pix_vld in reset", 32'(pix_vld), 0);
      rst_n = 1'b1;
      idle(3);

      // vector table: R1 R2 R3 R5 R6 R7 R8
      for (int v = 0; v < 6; v++) begin
         int w, hexp, hfirst;
         cfg_hs_start = 11'(VECS[v].s);
         cfg_hs_len   = 11'(VECS[v].l);
         cfg_hs_pol   = VECS[v].pol[0];
         cfg_latency  = 6'(VECS[v].lat);
         cfg_pairs    = 11'(VECS[v].n);
         idle(3);
         w = VECS[v].s + VECS[v].lat;
         hexp = (VECS[v].l < 40 - VECS[v].s) ? VECS[v].l : 40 - VECS[v].s;
         hfirst = (VECS[v].l == 0) ? -1 : VECS[v].s;
         run_line(40, 40, v * 16, VECS[v].pol, 2 * w + v * 16, -1, 0);
         check($sformatf("R1 hsync start v%0d", v), hs_first, hfirst);
         check($sformatf("R3 hsync length v%0d", v), hs_cnt, hexp);
         check($sformatf("R2 idle level v%0d", v), idle_lvl, VECS[v].pol);
         check($sformatf("R5 blank activity v%0d", v), blank_hs + blank_act, 0);
         check($sformatf("R6 window start v%0d", v), act_first, w);
         check($sformatf("R6 window size v%0d", v), act_cnt, VECS[v].n);
         check($sformatf("R7 first pixel v%0d", v), pix_first, w + 1);
         check($sformatf("R7 pixel count v%0d", v), pix_cnt, 2 * VECS[v].n);
         check($sformatf("R7 R8 pixel values v%0d", v), pix_err, 0);
      end

      // R10: mid-line rewrite of the start position
      cfg_hs_start = 11'd3; cfg_hs_len = 11'd2; cfg_hs_pol = 1'b0;
      cfg_latency = 6'd0; cfg_pairs = 11'd2;
      idle(2);
      run_line(30, 10, 0, 0, 6, 1, 20);
      check("R10 line keeps old start", hs_first, 3);
      run_line(30, 10, 0, 0, 40, -1, 0);
      check("R10 next line uses new start", hs_first, 20);

      // R4: vsync on one numbered line
      cfg_vs_line = 11'd2;
      idle(2);
      frame_start = 1'b1;
      idle(1);
      frame_start = 1'b0;
      idle(2);
      for (int ln = 0; ln < 4; ln++) begin
         run_line(20, 20, 0, 0, 80, -1, 0);
         check($sformatf("R4 vsync cycles line %0d", ln), vs_cnt, (ln == 2) ? 20 : 0);
      end

      // R9: clock enable gating
      gate_en = 1'b1; line_act = 1'b0;
      #1;
      check("R9 gated in blanking", 32'(clk_en), 0);
      line_act = 1'b1;
      #1;
      check("R9 enabled in active video", 32'(clk_en), 1);
      gate_en = 1'b0; line_act = 1'b0;
      #1;
      check("R9 ungated in blanking", 32'(clk_en), 1);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule